// File: doc/BRIEF.md
# Power Management Event and Wakeup Matrix

This block gathers system activity into four power-management strobes. Two activity strobes restart external idle timers: the primary one and a secondary one. Two wake strobes ask the system to leave reduced-speed operation, or to restart a CPU clock that has been gated off. The activity sources are interrupt request lines, CPU INTR and NMI, decoded I/O access strobes, a video-memory access strobe, bus-hold acknowledge and an external event pin. Each strobe has its own 32-bit enable register, which picks the sources that drive it.

The primary strobes can take nearly every source, one enable bit per source. The secondary strobes have only a few direct sources. Their chain bit takes the matching primary result as an extra source, so the secondary selection extends the primary one. A common secondary activity setup is the primary result plus IRQ0, which times the active window of the timer tick. Each wake strobe can also raise a system-management interrupt request.

The block is clocked by a free-running clock that keeps running while the CPU clock is gated. A CPU with a stopped clock cannot produce port accesses or hold acknowledges, so the secondary wake path relies on level sources such as INTR, NMI and the external pin.

Top module: `pm_event_matrix`

## Requirements
- R1: A synchronous reset clears all six outputs and all four enable registers, so no source drives any output until enables are written.
- R2: A write with `cfg_we_i` high loads `cfg_wdata_i` into the register picked by `cfg_sel_i`: 0 primary activity, 1 primary wake, 2 secondary activity, 3 secondary wake. The new value applies from the clock edge after the write edge. Bit 31 of the two activity registers is always stored as 0.
- R3: Each output is registered. A source that is active before clock edge N sets an enabled output after edge N. Primary enable bits: 0 IRQ0, 1 IRQ1, 2 IRQ3/4/5/7, 3 IRQ6/14, 4 IRQ9/13, 5 IRQ8/10/11/12/15, 6..13 `io_hit_i[0..7]` (floppy, IDE, COM1/2, COM3/4, LPT, keyboard, programmable range 1, programmable range 2), 14 video memory, 15 hold-acknowledge rise, 16 external pin, 17 INTR, 18 NMI.
- R4: A source whose enable bit is clear has no effect on the output.
- R5: I/O strobes, the video strobe and `hlda_i` are edge sources. A rising edge gives a strobe of exactly one cycle, even if the input stays high.
- R6: IRQ lines, INTR, NMI and the external pin are level sources. The output stays high on every cycle that such a source stays asserted.
- R7: IRQ2 belongs to no group and never drives any output. Any line of a group drives that group's bit.
- R8: Secondary enable bits: 0 chain (the matching primary result from the same cycle), 1 IRQ0, 2 INTR, 3 NMI, 4 external pin. With the chain bit clear, a primary hit does not reach the secondary output.
- R9: The secondary direct sources drive the secondary outputs without any primary enable.
- R10: Bit 31 of each wake register enables its SMI request. `smi_a_o` or `smi_b_o` is high exactly when its wake output is high and bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Enable register write strobe |
| cfg_sel_i | input | 2 | Enable register select |
| cfg_wdata_i | input | 32 | Enable register write data |
| irq_i | input | 16 | Interrupt request lines, level |
| io_hit_i | input | 8 | Decoded I/O access strobes |
| vmem_hit_i | input | 1 | Video memory access strobe |
| hlda_i | input | 1 | Bus hold acknowledge |
| ext_evt_i | input | 1 | External event pin, level |
| intr_i | input | 1 | CPU INTR, level |
| nmi_i | input | 1 | CPU NMI, level |
| evt_a_o | output | 1 | Primary activity strobe |
| evt_b_o | output | 1 | Secondary activity strobe |
| wake_a_o | output | 1 | Return-to-full-speed request |
| wake_b_o | output | 1 | CPU clock restart request |
| smi_a_o | output | 1 | SMI request from primary wake |
| smi_b_o | output | 1 | SMI request from secondary wake |

## Verification
The hardest case is the difference between edge and level sources under a long hold. Hold acknowledge and INTR must each stay high for several cycles, and the bench must sample each cycle separately to see one pulse for the first and a steady output for the second. The bench also makes a register write and an active source meet in the same cycle. This shows that the old enable value still decides that cycle and the new value decides the next one. It then clears the chain bit while a primary hit is present, to show that the secondary path drops it.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int IRQ_W   = 16;
    localparam int IO_W    = 8;
    localparam int CFG_W   = 32;
    localparam int GRP_W   = 6;
    localparam int A_SRC_W = GRP_W + IO_W + 5;
    localparam int B_SRC_W = 5;
    localparam int SMI_BIT = CFG_W - 1;
    localparam int N_REG   = 4;

    typedef enum logic [1:0] {
        SEL_EVT_A  = 2'd0,
        SEL_WAKE_A = 2'd1,
        SEL_EVT_B  = 2'd2,
        SEL_WAKE_B = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [IRQ_W-1:0] irq;
        logic [IO_W-1:0]  io;
        logic             vmem;
        logic             hlda;
        logic             ext;
        logic             intr;
        logic             nmi;
    } raw_src_t;

    typedef struct packed {
        logic evt_a;
        logic evt_b;
        logic wake_a;
        logic wake_b;
        logic smi_a;
        logic smi_b;
    } pm_out_t;

    function automatic logic [GRP_W-1:0] irq_groups(input logic [IRQ_W-1:0] irq);
        logic [GRP_W-1:0] g;
        g[0] = irq[0];
        g[1] = irq[1];
        g[2] = irq[3] | irq[4] | irq[5] | irq[7];
        g[3] = irq[6] | irq[14];
        g[4] = irq[9] | irq[13];
        g[5] = irq[8] | irq[10] | irq[11] | irq[12] | irq[15];
        return g;
    endfunction
endpackage

// File: rtl/pm_src_cond.sv
module pm_src_cond
    import pm_evt_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  raw_src_t           raw_i,
    output logic [A_SRC_W-1:0] a_src_o
);
    logic [IO_W-1:0] io_prev_q;
    logic            vmem_prev_q;
    logic            hlda_prev_q;
    logic            unused_irq2;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            io_prev_q   <= '0;
            vmem_prev_q <= 1'b0;
            hlda_prev_q <= 1'b0;
        end else begin
            io_prev_q   <= raw_i.io;
            vmem_prev_q <= raw_i.vmem;
            hlda_prev_q <= raw_i.hlda;
        end
    end

    assign unused_irq2 = raw_i.irq[2];

    always_comb begin
        a_src_o = {raw_i.nmi,
                   raw_i.intr,
                   raw_i.ext,
                   raw_i.hlda & ~hlda_prev_q,
                   raw_i.vmem & ~vmem_prev_q,
                   raw_i.io & ~io_prev_q,
                   irq_groups(raw_i.irq)};
    end

    // IRQ2 must never reach the source vector
    AST_IRQ2_ISOLATED: assert property (@(posedge clk_i) disable iff (rst_i)
        (raw_i.irq == 16'h0004) |-> (a_src_o[GRP_W-1:0] == '0)) // R7
        else $error("irq2 leaked");
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_evt_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        we_i,
    input  cfg_sel_e                    sel_i,
    input  logic [CFG_W-1:0]            wdata_i,
    output logic [N_REG-1:0][CFG_W-1:0] en_o
);
    logic [N_REG-1:0][CFG_W-1:0] en_q;

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        localparam bit IS_WAKE = (r == int'(SEL_WAKE_A)) || (r == int'(SEL_WAKE_B));
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                en_q[r] <= '0;
            end else if (we_i && (int'(sel_i) == r)) begin
                en_q[r] <= IS_WAKE ? wdata_i : {1'b0, wdata_i[CFG_W-2:0]};
            end
        end
    end

    assign en_o = en_q;

    AST_EVT_SMI_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_q[SEL_EVT_A][SMI_BIT] && !en_q[SEL_EVT_B][SMI_BIT]) // R2
        else $error("activity register holds smi bit");
endmodule

// File: rtl/pm_evt_combine.sv
module pm_evt_combine
    import pm_evt_pkg::*;
#(
    parameter int SRC_W = A_SRC_W
) (
    input  logic [SRC_W-1:0] src_i,
    input  logic [CFG_W-1:0] en_i,
    output logic             hit_o,
    output logic             smi_o
);
    localparam int PAD_W = CFG_W - 1 - SRC_W;

    logic [CFG_W-2:0] src_pad;

    if (PAD_W > 0) begin : g_pad
        assign src_pad = {{PAD_W{1'b0}}, src_i};
    end else begin : g_nopad
        assign src_pad = src_i;
    end

    assign hit_o = |(src_pad & en_i[CFG_W-2:0]);
    assign smi_o = hit_o & en_i[SMI_BIT];
endmodule

// File: rtl/pm_event_matrix.sv
module pm_event_matrix
    import pm_evt_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        cfg_we_i,
    input  logic [1:0]  cfg_sel_i,
    input  logic [31:0] cfg_wdata_i,
    input  logic [15:0] irq_i,
    input  logic [7:0]  io_hit_i,
    input  logic        vmem_hit_i,
    input  logic        hlda_i,
    input  logic        ext_evt_i,
    input  logic        intr_i,
    input  logic        nmi_i,
    output logic        evt_a_o,
    output logic        evt_b_o,
    output logic        wake_a_o,
    output logic        wake_b_o,
    output logic        smi_a_o,
    output logic        smi_b_o
);
    raw_src_t                    raw;
    logic [A_SRC_W-1:0]          a_src;
    logic [N_REG-1:0][CFG_W-1:0] en;
    logic [N_REG-1:0]            hit;
    logic [N_REG-1:0]            smi;
    logic [B_SRC_W-1:0]          b_src_evt;
    logic [B_SRC_W-1:0]          b_src_wake;
    pm_out_t                     out_q;

    assign raw = '{irq: irq_i, io: io_hit_i, vmem: vmem_hit_i, hlda: hlda_i,
                   ext: ext_evt_i, intr: intr_i, nmi: nmi_i};

    pm_src_cond i_cond (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .raw_i   (raw),
        .a_src_o (a_src)
    );

    pm_cfg_regs i_cfg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_e'(cfg_sel_i)),
        .wdata_i (cfg_wdata_i),
        .en_o    (en)
    );

    // secondary source vector: chain, IRQ0, INTR, NMI, external
    assign b_src_evt  = {ext_evt_i, nmi_i, intr_i, irq_i[0], hit[SEL_EVT_A]};
    assign b_src_wake = {ext_evt_i, nmi_i, intr_i, irq_i[0], hit[SEL_WAKE_A]};

    for (genvar k = 0; k < N_REG; k++) begin : g_comb
        if (k == int'(SEL_EVT_A) || k == int'(SEL_WAKE_A)) begin : g_prim
            pm_evt_combine #(.SRC_W(A_SRC_W)) i_comb (
                .src_i (a_src),
                .en_i  (en[k]),
                .hit_o (hit[k]),
                .smi_o (smi[k])
            );
        end else begin : g_sec
            pm_evt_combine #(.SRC_W(B_SRC_W)) i_comb (
                .src_i ((k == int'(SEL_EVT_B)) ? b_src_evt : b_src_wake),
                .en_i  (en[k]),
                .hit_o (hit[k]),
                .smi_o (smi[k])
            );
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= '{evt_a:  hit[SEL_EVT_A],
                       evt_b:  hit[SEL_EVT_B],
                       wake_a: hit[SEL_WAKE_A],
                       wake_b: hit[SEL_WAKE_B],
                       smi_a:  smi[SEL_WAKE_A],
                       smi_b:  smi[SEL_WAKE_B]};
        end
    end

    assign evt_a_o  = out_q.evt_a;
    assign evt_b_o  = out_q.evt_b;
    assign wake_a_o = out_q.wake_a;
    assign wake_b_o = out_q.wake_b;
    assign smi_a_o  = out_q.smi_a;
    assign smi_b_o  = out_q.smi_b;

    AST_NO_EN_NO_EVT_A: assert property (@(posedge clk_i) disable iff (rst_i)
        (en[SEL_EVT_A] == '0) |=> !evt_a_o) // R4
        else $error("evt_a without enables");
    AST_CHAIN_B: assert property (@(posedge clk_i) disable iff (rst_i)
        (en[SEL_EVT_B][0] && hit[SEL_EVT_A]) |=> evt_b_o) // R8
        else $error("chain not forwarded");
    AST_INTR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (en[SEL_WAKE_B][2] && intr_i) |=> wake_b_o) // R6
        else $error("intr level lost");
    AST_SMI_A_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        smi_a_o |-> wake_a_o) // R10
        else $error("smi_a without wake_a");
    AST_SMI_B_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        smi_b_o |-> wake_b_o) // R10
        else $error("smi_b without wake_b");
    AST_EVT_NO_SMI: assert property (@(posedge clk_i) disable iff (rst_i)
        !smi[SEL_EVT_A] && !smi[SEL_EVT_B]) // R10
        else $error("activity path raised smi");
endmodule

// File: tb/test_pm_event_matrix.sv
module test_pm_event_matrix;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [15:0] irq;
    logic [7:0]  io;
    logic        vmem, hlda, ext, intr, nmi;
    logic        evt_a, evt_b, wake_a, wake_b, smi_a, smi_b;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    pm_event_matrix i_pm_event_matrix (
        .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .irq_i(irq), .io_hit_i(io), .vmem_hit_i(vmem),
        .hlda_i(hlda), .ext_evt_i(ext), .intr_i(intr), .nmi_i(nmi),
        .evt_a_o(evt_a), .evt_b_o(evt_b), .wake_a_o(wake_a), .wake_b_o(wake_b),
        .smi_a_o(smi_a), .smi_b_o(smi_b)
    );

    // {irq, io, vmem, hlda, ext, intr, nmi} | {evt_a, evt_b, wake_a, wake_b, smi_a, smi_b}
    localparam int NV = 14;
    localparam logic [34:0] VEC [NV] = '{
        {16'h0000, 8'h00, 5'b00000, 6'b000000},
        {16'h0002, 8'h00, 5'b00000, 6'b110000},  // R3 IRQ1 + R8 chain
        {16'h0001, 8'h00, 5'b00000, 6'b010000},  // R9 IRQ0 direct
        {16'h0000, 8'h01, 5'b00000, 6'b110000},  // R3 floppy
        {16'h0000, 8'h04, 5'b00000, 6'b001010},  // R3 COM1/2 + R10
        {16'h0000, 8'h00, 5'b01000, 6'b001010},  // R5 hlda rise
        {16'h0000, 8'h00, 5'b00100, 6'b001010},  // R6 ext on wake A only
        {16'h0000, 8'h00, 5'b00010, 6'b000101},  // R9 intr
        {16'h0000, 8'h00, 5'b00001, 6'b000101},  // R9 nmi
        {16'h0000, 8'h00, 5'b10000, 6'b110000},  // R3 video
        {16'h1000, 8'h00, 5'b00000, 6'b110000},  // R7 IRQ12 group
        {16'h0004, 8'h00, 5'b00000, 6'b000000},  // R7 IRQ2 ignored
        {16'h0000, 8'h02, 5'b00000, 6'b000000},  // R4 IDE disabled
        {16'h4000, 8'h00, 5'b00000, 6'b000000}   // R4 IRQ6/14 disabled
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [28:0] s);
        {irq, io, vmem, hlda, ext, intr, nmi} = s;
    endtask

    task automatic check(input logic [5:0] exp, input string req);
        logic [5:0] act;
        act = {evt_a, evt_b, wake_a, wake_b, smi_a, smi_b};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        drive(29'h1FFF_FFFF);
        step(); step();
        check(6'b000000, "R1 in reset");
        rst = 1'b0;
        step();
        check(6'b000000, "R1 enables cleared after reset");
        drive('0);
        step();

        wr(2'd0, 32'h0000_4062);
        wr(2'd1, 32'h8001_8100);
        wr(2'd2, 32'h0000_0003);
        wr(2'd3, 32'h8000_000C);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][34:6]);
            step();
            check(VEC[v][5:0], $sformatf("R3/R4/R7/R9 vector %0d", v));
            drive('0);
            step();
        end

        // R5: held hold-acknowledge gives one pulse
        hlda = 1'b1;
        step(); check(6'b001010, "R5 hlda first cycle");
        step(); check(6'b000000, "R5 hlda held");
        step(); check(6'b000000, "R5 hlda held longer");
        hlda = 1'b0; step();

        // R6: held INTR keeps wake_b high
        intr = 1'b1;
        for (int c = 0; c < 3; c++) begin
            step(); check(6'b000101, "R6 intr held");
        end
        intr = 1'b0; step();
        check(6'b000000, "R6 intr released");

        // R8: chain bit cleared blocks primary result
        wr(2'd2, 32'h8000_0002);
        irq = 16'h0002;
        step(); check(6'b100000, "R8 chain off");
        irq = 16'h0000; step();

        // R10: wake without smi enable; R2 activity bit 31 forced clear
        wr(2'd1, 32'h0001_0000);
        ext = 1'b1;
        step(); check(6'b001000, "R10 smi disabled");

        // R2: write in the same cycle as source uses old enables
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0001_0000;
        step(); check(6'b001000, "R2 write cycle old value");
        cfg_we = 1'b0;
        step(); check(6'b101000, "R2 new value applied");
        ext = 1'b0; step();
        check(6'b000000, "R4 all idle");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule